// File: doc/BRIEF.md
# External Memory Address Router

This block routes each data-memory access of a small 8-bit CPU to one of two targets: the on-chip RAM or an off-chip parallel bus. A 2-bit mode input and the access form together decide the target and the effective address. The access form is either a short access (upper byte from a page register, lower byte from an index register) or a wide access (a 16-bit data pointer). The block also decides which bytes of the off-chip address bus are actively driven. The upper byte is left undriven in some modes, so that port latches can supply it.

On-chip accesses complete in the cycle they are presented. Off-chip accesses run a registered sequence: one setup cycle, a parameterised strobe phase, then one hold cycle in which ready is raised. The CPU holds its request until it sees ready. Address, byte enables, direction and write data are captured when an off-chip access is accepted, and they stay fixed for the whole sequence.

Top module: `xmr_router`

## Requirements
- R1: Mode 2'b00 sends every access to on-chip RAM, with address equal to the effective address modulo 8 KB (0x2000 and 0x4000 both reach RAM location 0x0000); no off-chip sequence starts in this mode.
- R2: Mode 2'b11 sends every access off-chip; a short access there ignores the page register, drives ext_addr[7:0] from the index register with ext_oe_lo=1 and leaves ext_oe_hi=0.
- R3: In modes 2'b01 and 2'b10, an effective address below 0x2000 goes on-chip and an address at or above 0x2000 goes off-chip, compared on the full 16 bits before any wrap.
- R4: The effective address of a short access (req_wide=0) is {page_reg, index_reg}; that of a wide access (req_wide=1) is dptr.
- R5: In mode 2'b01 an off-chip short access drives ext_addr[7:0] from the index register with ext_oe_lo=1 and ext_oe_hi=0.
- R6: In mode 2'b10 an off-chip short access drives both bytes, ext_addr = {page_reg, index_reg}, ext_oe_hi=ext_oe_lo=1.
- R7: Every off-chip wide access drives ext_addr = dptr with both byte enables high.
- R8: An off-chip access, accepted at a clock edge, shows one setup cycle (enables on, no strobe), then STROBE_CYC cycles with ext_rd (read) or ext_wr (write), then one hold cycle with no strobe and ready=1; address and enables hold steady through it even if the request inputs change.
- R9: An on-chip access raises ram_sel and ready in the cycle it is presented, with ram_we equal to req_write, ram_wdata equal to wdata and rdata equal to ram_rdata.
- R10: Outside an off-chip sequence, ext_oe_hi, ext_oe_lo, ext_rd and ext_wr are all low, including after reset.
- R11: During an off-chip write, ext_wdata equals the write data given with the request; in the hold cycle of an off-chip read, rdata equals ext_rdata sampled in the last strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Routing mode |
| req_valid | input | 1 | Access request, held until ready |
| req_wide | input | 1 | 1 = 16-bit pointer access, 0 = short access |
| req_write | input | 1 | 1 = write, 0 = read |
| page_reg | input | 8 | Page register (short access high byte) |
| index_reg | input | 8 | Index register (short access low byte) |
| dptr | input | 16 | 16-bit data pointer |
| wdata | input | 8 | Write data |
| ready | output | 1 | Access completes at the next clock edge |
| rdata | output | 8 | Read data |
| ram_sel | output | 1 | On-chip RAM select |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 13 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data |
| ext_addr | output | 16 | Off-chip address bus |
| ext_oe_hi | output | 1 | Drive enable for ext_addr[15:8] |
| ext_oe_lo | output | 1 | Drive enable for ext_addr[7:0] |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rdata | input | 8 | Off-chip read data |

## Verification
Two things can land in the same cycle. One is an off-chip sequence that is still running. The other is a change of mode, page, index or pointer inputs that would route a fresh access elsewhere. In the first strobe cycle of every off-chip access, the bench replaces all of these inputs with random values. It then requires the address, the byte enables and the strobe direction of every later cycle to match the values computed when the access was accepted. The change must not reach the on-chip select either.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

    typedef enum logic [1:0] {
        MODE_INT   = 2'b00,
        MODE_SPLIT = 2'b01,
        MODE_BANK  = 2'b10,
        MODE_EXT   = 2'b11
    } xmr_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_HOLD
    } xmr_seq_e;

    typedef struct packed {
        logic        onchip;
        logic        drive_hi;
        logic [15:0] addr;
    } xmr_route_t;

    function automatic logic [15:0] short_addr(input logic [7:0] page,
                                               input logic [7:0] index);
        return {page, index};
    endfunction

endpackage

// File: rtl/xmr_decode.sv
module xmr_decode
    import xmr_pkg::*;
#(
    parameter int ONCHIP_LIMIT = 32'h2000
) (
    input  logic [1:0]  mode,
    input  logic        wide,
    input  logic [7:0]  page,
    input  logic [7:0]  index,
    input  logic [15:0] dptr,
    output xmr_route_t  route
);
    localparam logic [16:0] LIMIT17 = 17'(ONCHIP_LIMIT);

    logic [15:0] eff;
    logic        below;

    always_comb begin
        eff   = wide ? dptr : short_addr(page, index);
        below = ({1'b0, eff} < LIMIT17);
        route = '0;
        unique case (xmr_mode_e'(mode))
            MODE_INT: begin
                route.onchip   = 1'b1;
                route.drive_hi = 1'b0;
                route.addr     = eff;
            end
            MODE_SPLIT: begin
                route.onchip   = below;
                route.drive_hi = wide;
                route.addr     = eff;
            end
            MODE_BANK: begin
                route.onchip   = below;
                route.drive_hi = 1'b1;
                route.addr     = eff;
            end
            default: begin
                route.onchip   = 1'b0;
                route.drive_hi = wide;
                route.addr     = wide ? dptr : {8'h00, index};
            end
        endcase
    end

endmodule

// File: rtl/xmr_ext_seq.sv
module xmr_ext_seq
    import xmr_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [15:0]   addr_in,
    input  logic          hi_in,
    input  logic          write_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] ext_rdata,
    output logic          busy,
    output logic          done,
    output logic [15:0]   ext_addr,
    output logic          ext_oe_hi,
    output logic          ext_oe_lo,
    output logic          ext_rd,
    output logic          ext_wr,
    output logic [DW-1:0] ext_wdata,
    output logic [DW-1:0] rdata_q
);
    localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(STROBE_CYC - 1);

    xmr_seq_e      state;
    logic [CW-1:0] cnt;
    logic [15:0]   addr_q;
    logic          hi_q;
    logic          wr_q;
    logic [DW-1:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            hi_q    <= 1'b0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state  <= SEQ_SETUP;
                        addr_q <= addr_in;
                        hi_q   <= hi_in;
                        wr_q   <= write_in;
                        wd_q   <= wdata_in;
                    end
                end
                SEQ_SETUP: begin
                    state <= SEQ_STROBE;
                    cnt   <= CNT_LOAD;
                end
                SEQ_STROBE: begin
                    if (cnt == '0) begin
                        state <= SEQ_HOLD;
                        if (!wr_q) rdata_q <= ext_rdata;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != SEQ_IDLE);
        done      = (state == SEQ_HOLD);
        ext_oe_lo = busy;
        ext_oe_hi = busy && hi_q;
        ext_rd    = (state == SEQ_STROBE) && !wr_q;
        ext_wr    = (state == SEQ_STROBE) && wr_q;
        ext_addr  = '0;
        if (busy) begin
            ext_addr[7:0]  = addr_q[7:0];
            ext_addr[15:8] = hi_q ? addr_q[15:8] : 8'h00;
        end
        ext_wdata = busy ? wd_q : '0;
    end

    // R8: first cycle of a sequence carries no strobe
    a_r8_setup_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_oe_lo) |-> (!ext_rd && !ext_wr));
    // R8: hold cycle carries no strobe
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ext_rd && !ext_wr));
    // R8: address steady while sequence runs
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (ext_oe_lo && $past(ext_oe_lo)) |-> $stable(ext_addr));
    // R10: strobes only inside a driven sequence
    a_r10_strobe_in_seq: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |-> ext_oe_lo);
    // R5: high byte never driven alone
    a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (rst)
        ext_oe_hi |-> ext_oe_lo);
    // R8: never both strobes
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(ext_rd && ext_wr));

endmodule

// File: rtl/xmr_router.sv
module xmr_router
    import xmr_pkg::*;
#(
    parameter int ONCHIP_LIMIT = 32'h2000,
    parameter int RAM_AW       = 13,
    parameter int STROBE_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic              req_write,
    input  logic [7:0]        page_reg,
    input  logic [7:0]        index_reg,
    input  logic [15:0]       dptr,
    input  logic [7:0]        wdata,
    output logic              ready,
    output logic [7:0]        rdata,
    output logic              ram_sel,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic [15:0]       ext_addr,
    output logic              ext_oe_hi,
    output logic              ext_oe_lo,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [7:0]        ext_wdata,
    input  logic [7:0]        ext_rdata
);
    xmr_route_t route;
    logic       busy;
    logic       done;
    logic       start;
    logic [7:0] ext_rd_q;

    xmr_decode #(.ONCHIP_LIMIT(ONCHIP_LIMIT)) u_decode (
        .mode  (mode),
        .wide  (req_wide),
        .page  (page_reg),
        .index (index_reg),
        .dptr  (dptr),
        .route (route)
    );

    xmr_ext_seq #(.STROBE_CYC(STROBE_CYC), .DW(8)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .addr_in   (route.addr),
        .hi_in     (route.drive_hi),
        .write_in  (req_write),
        .wdata_in  (wdata),
        .ext_rdata (ext_rdata),
        .busy      (busy),
        .done      (done),
        .ext_addr  (ext_addr),
        .ext_oe_hi (ext_oe_hi),
        .ext_oe_lo (ext_oe_lo),
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .ext_wdata (ext_wdata),
        .rdata_q   (ext_rd_q)
    );

    always_comb begin
        ram_sel   = req_valid && !busy && route.onchip;
        start     = req_valid && !busy && !route.onchip;
        ram_we    = ram_sel && req_write;
        ram_addr  = route.addr[RAM_AW-1:0];
        ram_wdata = wdata;
        ready     = ram_sel || done;
        rdata     = done ? ext_rd_q : ram_rdata;
    end

    // R9: on-chip select never overlaps an off-chip sequence
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> !ext_oe_lo);
    // R1: internal-only mode never starts an off-chip sequence
    a_r1_no_ext_in_int: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_oe_lo) |-> ($past(mode) != 2'b00));

endmodule

// File: tb/xmr_router_tb.sv
`timescale 1ns/1ps
module xmr_router_tb;
    localparam int LIMIT = 32'h2000;
    localparam int AW    = 13;
    localparam int SC    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        req_valid = 1'b0, req_wide = 1'b0, req_write = 1'b0;
    logic [7:0]  page_reg = 8'h00, index_reg = 8'h00, wdata = 8'h00;
    logic [15:0] dptr = 16'h0000;
    logic [7:0]  ram_rdata = 8'h00, ext_rdata = 8'h00;
    logic        ready, ram_sel, ram_we, ext_oe_hi, ext_oe_lo, ext_rd, ext_wr;
    logic [7:0]  rdata, ram_wdata, ext_wdata;
    logic [AW-1:0] ram_addr;
    logic [15:0] ext_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xmr_router #(.ONCHIP_LIMIT(LIMIT), .RAM_AW(AW), .STROBE_CYC(SC)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
        .req_wide(req_wide), .req_write(req_write), .page_reg(page_reg),
        .index_reg(index_reg), .dptr(dptr), .wdata(wdata), .ready(ready),
        .rdata(rdata), .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ext_addr(ext_addr),
        .ext_oe_hi(ext_oe_hi), .ext_oe_lo(ext_oe_lo), .ext_rd(ext_rd),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] f_eff(input logic w, input logic [7:0] p,
                                          input logic [7:0] i, input logic [15:0] d);
        return w ? d : {p, i};
    endfunction

    function automatic bit f_onchip(input logic [1:0] m, input logic [15:0] e);
        if (m == 2'b00) return 1'b1;
        if (m == 2'b11) return 1'b0;
        return (32'(e) < LIMIT);
    endfunction

    function automatic bit f_hi(input logic [1:0] m, input logic w);
        if (w) return 1'b1;
        return (m == 2'b10);
    endfunction

    task automatic access(input logic [1:0] m, input logic w, input logic wr,
                          input logic [7:0] p, input logic [7:0] i,
                          input logic [15:0] d, input logic [7:0] wd);
        logic [15:0] e;
        bit on, hi;
        logic [7:0] ram_val, ext_val;
        e = f_eff(w, p, i, d);
        on = f_onchip(m, e);
        hi = f_hi(m, w);
        ram_val = 8'($urandom);
        ext_val = 8'($urandom);
        @(negedge clk);
        mode = m; req_wide = w; req_write = wr; page_reg = p; index_reg = i;
        dptr = d; wdata = wd; ram_rdata = ram_val; ext_rdata = ext_val;
        req_valid = 1'b1;
        #1;
        if (on) begin
            chk("R1/R3 on-chip select", ram_sel, 1);
            chk("R9 ready same cycle", ready, 1);
            chk("R1/R4 ram address wrap", ram_addr, e[AW-1:0]);
            chk("R9 ram write enable", ram_we, wr);
            chk("R9 ram write data", ram_wdata, wd);
            chk("R9 read data path", rdata, ram_val);
            chk("R10 no enables for on-chip", {ext_oe_hi, ext_oe_lo, ext_rd, ext_wr}, 0);
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            chk("R2/R3 not on-chip", ram_sel, 0);
            chk("R10 idle before accept", {ext_oe_hi, ext_oe_lo, ext_rd, ext_wr, ready}, 0);
            for (int k = 0; k < SC + 2; k++) begin
                @(negedge clk);
                #1;
                if (k == 1) begin
                    mode = 2'($urandom); page_reg = 8'($urandom);
                    index_reg = 8'($urandom); dptr = 16'($urandom);
                    req_wide = 1'($urandom);
                    #0.5;
                end
                chk("R8 low enable", ext_oe_lo, 1);
                chk("R2/R5/R6/R7 high enable", ext_oe_hi, hi);
                chk("R2/R4/R5 low address byte", ext_addr[7:0], e[7:0]);
                if (hi) chk("R6/R7 high address byte", ext_addr[15:8], e[15:8]);
                chk("R9 no ram select during sequence", ram_sel, 0);
                if (k == 0 || k == SC + 1) begin
                    chk("R8 no strobe in setup/hold", {ext_rd, ext_wr}, 0);
                end else begin
                    chk("R8 read strobe", ext_rd, !wr);
                    chk("R8 write strobe", ext_wr, wr);
                end
                if (wr) chk("R11 write data", ext_wdata, wd);
                chk("R8 ready only in hold", ready, (k == SC + 1));
                if (k == SC + 1 && !wr) chk("R11 read data", rdata, ext_val);
            end
            req_valid = 1'b0;
            @(negedge clk);
            #1;
            chk("R10 quiet after sequence", {ext_oe_hi, ext_oe_lo, ext_rd, ext_wr, ready}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset state", {ext_oe_hi, ext_oe_lo, ext_rd, ext_wr, ready, ram_sel}, 0);

        // directed corners
        access(2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 16'h2000, 8'h11); // R1 wrap
        access(2'b00, 1'b1, 1'b1, 8'h00, 8'h00, 16'h4000, 8'h22); // R1 wrap
        access(2'b00, 1'b0, 1'b0, 8'h20, 8'h00, 16'h0000, 8'h00); // R1 short wrap
        access(2'b01, 1'b1, 1'b0, 8'h00, 8'h00, 16'h1FFF, 8'h00); // R3 below
        access(2'b01, 1'b1, 1'b1, 8'h00, 8'h00, 16'h2000, 8'h5A); // R3/R7 at
        access(2'b01, 1'b0, 1'b0, 8'h80, 8'h34, 16'h0000, 8'h00); // R5
        access(2'b10, 1'b0, 1'b1, 8'hC3, 8'h7E, 16'h0000, 8'hA5); // R6
        access(2'b10, 1'b0, 1'b0, 8'h1F, 8'hFF, 16'hFFFF, 8'h00); // R3/R4 short below
        access(2'b11, 1'b0, 1'b0, 8'h00, 8'h12, 16'h0000, 8'h00); // R2 page ignored
        access(2'b11, 1'b0, 1'b1, 8'hFF, 8'h99, 16'h0000, 8'h3C); // R2
        access(2'b11, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0005, 8'h00); // R7 below boundary

        // random mix
        for (int n = 0; n < 400; n++) begin
            access(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                   8'($urandom), 16'($urandom), 8'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule